// File: doc/BRIEF.md
# Memory-mapped keyboard and display port

This block connects a processor bus to one character source (a keyboard) and one character sink (a display). It claims a window of four consecutive byte addresses in the memory address space and answers only to reads and writes that land in that window. Inside the window there are four byte-wide registers: the received keyboard character, the character last sent to the display, a status byte and a control byte.

Software either polls the status byte or waits for the interrupt output. Reading the received-character register hands the buffered character to the processor and marks the buffer empty. Writing the output register passes a character to the display over a valid/ready handshake. The status byte carries two ready flags, a sticky overrun flag and two interrupt-request bits. Each request bit is a ready flag gated by its enable in the control byte, and the single interrupt line is the OR of the two requests.

The keyboard side always accepts a character. A character that arrives while the previous one has not been read is lost, and the loss is recorded. A write to the output register while the display still holds an earlier character is ignored.

Top module: `kbd_disp_if`

## Requirements
- R1: Only bus addresses from BASE_ADDR to BASE_ADDR+3 select the block. A write outside that window changes no register and no output. A read outside it returns 0 on `bus_rdata` after the next clock edge.
- R2: A read strobe that hits the window places the selected register on `bus_rdata` after the next rising clock edge, for one cycle. Otherwise `bus_rdata` is 0. The offsets are: 0 received keyboard character, 1 last character accepted for the display, 2 status, 3 control. `bus_rd` and `bus_wr` are never high together.
- R3: The status bits are: bit 0 input ready, bit 1 output ready, bit 2 overrun, bit 6 keyboard request, bit 7 display request. All other status bits read 0. The control bits are: bit 0 keyboard enable, bit 1 display enable. All other control bits are discarded on write and read 0.
- R4: `kb_ready` is always 1. `kb_valid` while input ready is 0 stores `kb_data` and sets input ready. A read of offset 0 returns the stored character and clears input ready.
- R5: `kb_valid` while input ready is 1, with no read of offset 0 in the same cycle, drops the character and sets overrun. Overrun stays set until a read of offset 2. That read returns it as 1 and then clears it. A new overrun event in the same cycle as that read keeps it set.
- R6: When a read of offset 0 and `kb_valid` fall in the same cycle, the read returns the older character. The new character is stored, input ready stays 1 and overrun is not set.
- R7: A write to offset 1 while output ready is 1 sets `dp_valid`, presents the written byte on `dp_data` after the next edge, and clears output ready. `dp_valid` and `dp_data` hold until a cycle with `dp_ready` high. At the edge after that cycle, `dp_valid` falls and output ready returns to 1.
- R8: A write to offset 1 while output ready is 0 is ignored: `dp_data` and `dp_valid` keep their values.
- R9: The keyboard request is input ready AND keyboard enable. The display request is output ready AND display enable. `irq` is the OR of the two requests and follows them in the same cycle.
- R10: After reset, input ready, overrun, both enables, `dp_valid`, `bus_rdata` and `irq` are 0, and output ready is 1, so status reads 0x02. Reset is applied at once and released two clock edges after `rst_n` rises.
- R11: Writes to offsets 0 and 2 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| kb_valid | input | 1 | Keyboard offers a character |
| kb_data | input | DATA_W | Keyboard character |
| kb_ready | output | 1 | Keyboard handshake ready (always 1) |
| dp_valid | output | 1 | Character offered to the display |
| dp_data | output | DATA_W | Display character |
| dp_ready | input | 1 | Display takes the character |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the processor never raises read and write strobes in the same cycle, and one of them flags any cycle that does. They also assume that the display side does not drop `dp_ready` back into a pending transfer in a way that needs more than the valid/ready rule. The bench drives every strobe, keyboard offer and display acceptance for exactly one cycle, changes them only on the falling clock edge, and issues a single bus access per task call. Corner cases such as a read colliding with a keyboard arrival are built by raising both in the same falling-edge window.

// File: rtl/kdi_pkg.sv
package kdi_pkg;

  // register offsets inside the four-byte window
  localparam int unsigned OFS_W    = 2;
  localparam int unsigned NREGS    = 1 << OFS_W;
  localparam int unsigned OFS_RXD  = 0;
  localparam int unsigned OFS_TXD  = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_CTRL = 3;

  // status byte bit positions
  localparam int unsigned ST_RX_RDY = 0;
  localparam int unsigned ST_TX_RDY = 1;
  localparam int unsigned ST_OVR    = 2;
  localparam int unsigned ST_RX_IRQ = 6;
  localparam int unsigned ST_TX_IRQ = 7;

  // control byte bit positions
  localparam int unsigned CT_RX_EN = 0;
  localparam int unsigned CT_TX_EN = 1;

endpackage

// File: rtl/kdi_decode.sv
module kdi_decode
  import kdi_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]     BASE_ADDR = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [NREGS-1:0]  rd_sel,
  output logic [NREGS-1:0]  wr_sel
);

  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tag;
  logic [OFS_W-1:0] ofs;
  logic             hit;

  assign tag = addr[ADDR_W-1:OFS_W];
  assign ofs = addr[OFS_W-1:0];
  assign hit = (tag == BASE_ADDR[ADDR_W-1:OFS_W]);

  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    assign rd_sel[i] = hit && rd && (ofs == OFS_W'(i));
    assign wr_sel[i] = hit && wr && (ofs == OFS_W'(i));
  end

endmodule

// File: rtl/kdi_kbd_chan.sv
module kdi_kbd_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_data,
  input  logic              rd_take,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              ovr
);

  logic rx_rdy_d;
  logic ovr_d;
  logic data_en;

  always_comb begin
    rx_rdy_d = rx_rdy;
    ovr_d    = ovr;
    data_en  = 1'b0;
    if (rd_take) begin
      rx_rdy_d = 1'b0;
    end
    if (clr_ovr) begin
      ovr_d = 1'b0;
    end
    if (kb_valid) begin
      if (!rx_rdy || rd_take) begin
        rx_rdy_d = 1'b1;
        data_en  = 1'b1;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      rx_rdy <= rx_rdy_d;
      ovr    <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (data_en) begin
      rx_data <= kb_data;
    end
  end

endmodule

// File: rtl/kdi_disp_chan.sv
module kdi_disp_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dp_ready,
  output logic              dp_valid,
  output logic [DATA_W-1:0] dp_data,
  output logic              tx_rdy
);

  logic valid_d;
  logic load_en;

  always_comb begin
    valid_d = dp_valid;
    load_en = 1'b0;
    if (dp_valid) begin
      if (dp_ready) begin
        valid_d = 1'b0;
      end
    end else if (wr_take) begin
      valid_d = 1'b1;
      load_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
    end else begin
      dp_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_data <= '0;
    end else if (load_en) begin
      dp_data <= wdata;
    end
  end

  assign tx_rdy = ~dp_valid;

endmodule

// File: rtl/kdi_regs.sv
module kdi_regs
  import kdi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREGS-1:0]  rd_sel,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rdy,
  input  logic              tx_rdy,
  input  logic              ovr,
  output logic              ken,
  output logic              den,
  output logic              kirq,
  output logic              dirq,
  output logic [DATA_W-1:0] rdata
);

  logic              ken_d;
  logic              den_d;
  logic [DATA_W-1:0] stat_v;
  logic [DATA_W-1:0] ctrl_v;
  logic [DATA_W-1:0] rdata_d;

  assign kirq = rx_rdy & ken;
  assign dirq = tx_rdy & den;

  always_comb begin
    stat_v            = '0;
    stat_v[ST_RX_RDY] = rx_rdy;
    stat_v[ST_TX_RDY] = tx_rdy;
    stat_v[ST_OVR]    = ovr;
    stat_v[ST_RX_IRQ] = kirq;
    stat_v[ST_TX_IRQ] = dirq;
    ctrl_v            = '0;
    ctrl_v[CT_RX_EN]  = ken;
    ctrl_v[CT_TX_EN]  = den;
  end

  always_comb begin
    ken_d = ken;
    den_d = den;
    if (wr_ctrl) begin
      ken_d = wdata[CT_RX_EN];
      den_d = wdata[CT_TX_EN];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_sel[OFS_RXD])  rdata_d = rdata_d | rx_data;
    if (rd_sel[OFS_TXD])  rdata_d = rdata_d | tx_data;
    if (rd_sel[OFS_STAT]) rdata_d = rdata_d | stat_v;
    if (rd_sel[OFS_CTRL]) rdata_d = rdata_d | ctrl_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ken   <= 1'b0;
      den   <= 1'b0;
      rdata <= '0;
    end else begin
      ken   <= ken_d;
      den   <= den_d;
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/kbd_disp_if.sv
module kbd_disp_if
  import kdi_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'hFF00,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_data,
  output logic              kb_ready,
  output logic              dp_valid,
  output logic [DATA_W-1:0] dp_data,
  input  logic              dp_ready,
  output logic              irq
);

  // reset: asserted at once, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  logic [NREGS-1:0]  rd_sel;
  logic [NREGS-1:0]  wr_sel;
  logic [DATA_W-1:0] rx_data;
  logic              rx_rdy;
  logic              tx_rdy;
  logic              ovr;
  logic              ken;
  logic              den;
  logic              kirq;
  logic              dirq;
  logic              unused_wr;

  kdi_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  // writes to the input data and status offsets are dropped
  assign unused_wr = ^{wr_sel[OFS_RXD], wr_sel[OFS_STAT]};

  kdi_kbd_chan #(
    .DATA_W (DATA_W)
  ) u_kbd (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .kb_valid (kb_valid),
    .kb_data  (kb_data),
    .rd_take  (rd_sel[OFS_RXD]),
    .clr_ovr  (rd_sel[OFS_STAT]),
    .rx_data  (rx_data),
    .rx_rdy   (rx_rdy),
    .ovr      (ovr)
  );

  kdi_disp_chan #(
    .DATA_W (DATA_W)
  ) u_disp (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_take  (wr_sel[OFS_TXD]),
    .wdata    (bus_wdata),
    .dp_ready (dp_ready),
    .dp_valid (dp_valid),
    .dp_data  (dp_data),
    .tx_rdy   (tx_rdy)
  );

  kdi_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_sel  (rd_sel),
    .wr_ctrl (wr_sel[OFS_CTRL]),
    .wdata   (bus_wdata),
    .rx_data (rx_data),
    .tx_data (dp_data),
    .rx_rdy  (rx_rdy),
    .tx_rdy  (tx_rdy),
    .ovr     (ovr),
    .ken     (ken),
    .den     (den),
    .kirq    (kirq),
    .dirq    (dirq),
    .rdata   (bus_rdata)
  );

  assign kb_ready = 1'b1;
  assign irq      = kirq | dirq;

endmodule

// File: rtl/kdi_checker.sv
module kdi_checker #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kb_valid,
  input logic              dp_valid,
  input logic [DATA_W-1:0] dp_data,
  input logic              dp_ready,
  input logic              irq,
  input logic              sin,
  input logic              sout,
  input logic              ovr,
  input logic              ken,
  input logic              den
);

  logic       in_win;
  logic [1:0] ofs;

  assign in_win = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign ofs    = bus_addr[1:0];

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_rd_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_win) |=> (bus_rdata == '0));

  p_kb_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && !sin) |=> sin);

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && sin && !(bus_rd && in_win && ofs == 2'd0)) |=> ovr);

  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && sin && bus_rd && in_win && ofs == 2'd0 && !ovr) |=> (sin && !ovr));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !dp_ready) |=> (dp_valid && $stable(dp_data)));

  p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_ready) |=> (!dp_valid && sout));

  p_tx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_win && ofs == 2'd1 && !sout) |=> $stable(dp_data));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sin && ken) || (sout && den)));

  p_irq_need_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sin && ken) || (sout && den)) |-> irq);

  p_rst_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sout && !sin && !ovr && !ken && !den && !dp_valid));

endmodule

bind kbd_disp_if kdi_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR)
) u_kdi_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .kb_valid  (kb_valid),
  .dp_valid  (dp_valid),
  .dp_data   (dp_data),
  .dp_ready  (dp_ready),
  .irq       (irq),
  .sin       (rx_rdy),
  .sout      (tx_rdy),
  .ovr       (ovr),
  .ken       (ken),
  .den       (den)
);

// File: tb/kbd_disp_if_tb_top.sv
`timescale 1ns/1ps
module kbd_disp_if_tb_top;

  localparam logic [15:0] BASE = 16'hFF00;
  localparam logic [15:0] A_RXD  = BASE + 16'd0;
  localparam logic [15:0] A_TXD  = BASE + 16'd1;
  localparam logic [15:0] A_STAT = BASE + 16'd2;
  localparam logic [15:0] A_CTRL = BASE + 16'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        kb_valid;
  logic [7:0]  kb_data;
  logic        kb_ready;
  logic        dp_valid;
  logic [7:0]  dp_data;
  logic        dp_ready;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  kbd_disp_if dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .kb_valid  (kb_valid),
    .kb_data   (kb_data),
    .kb_ready  (kb_ready),
    .dp_valid  (dp_valid),
    .dp_data   (dp_data),
    .dp_ready  (dp_ready),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic kb_send(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_data = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic dp_accept();
    @(negedge clk);
    dp_ready = 1'b1;
    @(negedge clk);
    dp_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R10 irq", {7'd0, irq}, 8'h00);
    check("R10 dp_valid", {7'd0, dp_valid}, 8'h00);
    check("R10 kb_ready R4", {7'd0, kb_ready}, 8'h01);
    check("R10 rdata", bus_rdata, 8'h00);
    bus_read(A_STAT, v); check("R10 R3 status", v, 8'h02);
    bus_read(A_CTRL, v); check("R10 control", v, 8'h00);
  endtask

  task automatic t_kbd();
    logic [7:0] v;
    kb_send(8'h41);
    bus_read(A_STAT, v); check("R4 status after key", v, 8'h03);
    bus_read(A_RXD, v);  check("R4 key data", v, 8'h41);
    @(negedge clk);      check("R2 rdata returns to 0", bus_rdata, 8'h00);
    bus_read(A_STAT, v); check("R4 status after read", v, 8'h02);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    kb_send(8'h11);
    kb_send(8'h22);
    bus_read(A_STAT, v); check("R5 status overrun", v, 8'h07);
    bus_read(A_STAT, v); check("R5 overrun cleared", v, 8'h03);
    bus_read(A_RXD, v);  check("R5 first key kept", v, 8'h11);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    kb_send(8'h33);
    @(negedge clk);
    bus_addr = A_RXD; bus_rd = 1'b1; kb_valid = 1'b1; kb_data = 8'h44;
    @(negedge clk);
    bus_rd = 1'b0; kb_valid = 1'b0;
    check("R6 read returns older", bus_rdata, 8'h33);
    bus_read(A_STAT, v); check("R6 status no overrun", v, 8'h03);
    bus_read(A_RXD, v);  check("R6 new key stored", v, 8'h44);
  endtask

  task automatic t_disp();
    logic [7:0] v;
    bus_write(A_TXD, 8'h5A);
    check("R7 dp_valid set", {7'd0, dp_valid}, 8'h01);
    check("R7 dp_data", dp_data, 8'h5A);
    bus_read(A_STAT, v); check("R7 status busy", v, 8'h00);
    bus_write(A_TXD, 8'h77);
    check("R8 dp_data unchanged", dp_data, 8'h5A);
    check("R8 dp_valid held", {7'd0, dp_valid}, 8'h01);
    @(negedge clk);
    check("R7 hold without ready", {7'd0, dp_valid}, 8'h01);
    dp_accept();
    check("R7 dp_valid drops", {7'd0, dp_valid}, 8'h00);
    bus_read(A_STAT, v); check("R7 status ready again", v, 8'h02);
    bus_read(A_TXD, v);  check("R2 output reg readback", v, 8'h5A);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_write(A_CTRL, 8'h01);
    check("R9 no irq without key", {7'd0, irq}, 8'h00);
    kb_send(8'h61);
    check("R9 keyboard irq", {7'd0, irq}, 8'h01);
    bus_read(A_STAT, v); check("R9 R3 status kirq", v, 8'h43);
    bus_read(A_RXD, v);
    check("R9 irq drops on read", {7'd0, irq}, 8'h00);
    bus_write(A_CTRL, 8'h02);
    check("R9 display irq", {7'd0, irq}, 8'h01);
    bus_read(A_STAT, v); check("R9 R3 status dirq", v, 8'h82);
    bus_read(A_CTRL, v); check("R3 control readback", v, 8'h02);
    bus_write(A_CTRL, 8'hFC);
    bus_read(A_CTRL, v); check("R3 control spare bits", v, 8'h00);
    check("R9 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] v;
    bus_write(BASE + 16'd5, 8'hA5);
    check("R1 alias write no display", {7'd0, dp_valid}, 8'h00);
    bus_write(BASE + 16'd7, 8'h03);
    bus_write(BASE - 16'd1, 8'h03);
    bus_read(A_CTRL, v); check("R1 control untouched", v, 8'h00);
    bus_read(A_STAT, v);
    bus_read(BASE + 16'd6, v); check("R1 outside read zero", v, 8'h00);
    kb_send(8'h66);
    bus_write(A_RXD, 8'h99);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, v); check("R11 status untouched", v, 8'h03);
    bus_read(A_RXD, v);  check("R11 key untouched", v, 8'h66);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    kb_valid = 1'b0; kb_data = '0; dp_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_kbd();
    t_overrun();
    t_collide();
    t_disp();
    t_irq();
    t_window();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule